// File: doc/BRIEF.md
# Framed Serial Pixel Packetizer with Embedded Sync

This block turns a parallel pixel stream (10-bit samples qualified by a line-valid flag, a frame-valid flag and a pixel-rate enable) into a continuous serial bit stream. The stream is made of fixed 12-bit packets. Each packet has a start bit, ten payload bits and a stop bit, and its least significant bit goes out first. A separate bit-rate enable, which pulses twelve times per pixel period, times the serial output. A strobe marks the first bit of every packet, so a receiver can find the packet boundaries without a separate clock line.

The block marks frame and line boundaries with reserved payload codes that it places in blanking slots. A frame opens with the sequence all-ones, zero, all-ones and then the start-of-line code. Every later line opens with the start-of-line code alone. A line closes with an end-of-line code, or with an end-of-frame code when the frame-valid flag has already dropped. Raw pixel values that could imitate these codes are raised to the smallest legal value. The block decides each slot after a fixed four-slot lookahead, so it can place the opening codes ahead of the first pixel of a line. A sticky flag reports when the blanking is too short to hold the codes a boundary needs.

A static mode input selects between two payload layouts. The first carries the full 10-bit pixel. The second carries the upper eight pixel bits together with copies of the line-valid and frame-valid flags.

Top module: `sync_packetizer`

## Requirements
- R1: Each packet is 12 bits, shifted out least significant bit first with one bit per `bit_en` cycle. Bit 0 is 1, bit 11 is 0, and `packet_start` is high on exactly the cycle that presents bit 0.
- R2: With `wide_mode`=1, packet bits 1 to 10 carry payload value bits 0 to 9 in ascending order.
- R3: With `wide_mode`=0, packet bits 1 to 8 carry an 8-bit payload. For a pixel this is pixel bits 2 to 9. For a code it is the code value, with all-ones (1023) mapped to 255. Bit 9 carries the slot's line-valid flag and bit 10 carries its frame-valid flag.
- R4: A pixel value below 4 is sent as 4. In 8-bit layout, an 8-bit pixel payload below 4 is sent as 4. As a result, the raw run 1023, 0, 1023 leaves the block as 1023, 4, 1023.
- R5: The first line after frame-valid was low is preceded, in the four slots just before its first pixel, by the payloads 1023, 0, 1023, 1.
- R6: Each later line in the same frame is preceded by payload 1 in the slot just before its first pixel.
- R7: The slot right after a line's last pixel carries payload 2 if frame-valid is high in that slot, and payload 3 if it is low.
- R8: Any slot that holds neither a pixel nor a code carries payload 0 (idle).
- R9: `sync_err` goes high when a line starts without its full set of opening codes in the slots just before it. The end-of-line code takes priority over opening codes. Once high, `sync_err` stays high until reset.
- R10: During reset `ser_out`, `packet_start` and `sync_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-slot enable; samples the parallel inputs |
| bit_en | input | 1 | Serial bit enable, twelve per pixel slot |
| wide_mode | input | 1 | 1: 10-bit payload layout, 0: 8-bit payload with flags |
| pix_in | input | 10 | Raw pixel value |
| line_valid | input | 1 | High while pixels of a line are presented |
| frame_valid | input | 1 | High while a frame is in progress |
| ser_out | output | 1 | Serial packet bit stream |
| packet_start | output | 1 | High on the bit-0 cycle of every packet |
| sync_err | output | 1 | Sticky flag: blanking too short for the required codes |

## Verification
The hardest condition to reach is a collision between boundary codes. Here the end-of-line code and the next line's opening code compete for a single blanking slot. Normal frames never cause this, so the stimulus places two lines of one frame only one blank slot apart. That run then checks that the flag rises and never falls again. The clean runs sweep every 10-bit pixel value through both layouts, with an extra frame that contains the reserved 1023, 0, 1023 run. Every packet in those runs is compared with a layout the bench builds from the input stream.

// File: rtl/spk_pkg.sv
package spk_pkg;

    localparam int PIX_W  = 10;
    localparam int NAR_W  = PIX_W - 2;
    localparam int PKT_W  = PIX_W + 2;
    localparam int LOOK   = 4;
    localparam int CW     = $clog2(LOOK + 1);
    localparam int BCW    = $clog2(PKT_W);

    localparam logic [PIX_W-1:0] CODE_IDLE  = '0;
    localparam logic [PIX_W-1:0] CODE_SOL   = PIX_W'(1);
    localparam logic [PIX_W-1:0] CODE_EOL   = PIX_W'(2);
    localparam logic [PIX_W-1:0] CODE_EOF   = PIX_W'(3);
    localparam logic [PIX_W-1:0] CODE_MAX   = '1;
    localparam logic [PIX_W-1:0] PIX_FLOOR  = PIX_W'(4);
    localparam logic [NAR_W-1:0] NAR_FLOOR  = NAR_W'(4);

    typedef struct packed {
        logic             lv;
        logic             fv;
        logic [PIX_W-1:0] pix;
    } samp_t;

    typedef struct packed {
        logic             lv;
        logic             fv;
        logic             is_code;
        logic [PIX_W-1:0] val;
    } sym_t;

    function automatic logic [PIX_W-1:0] floor_pix(input logic [PIX_W-1:0] v);
        return (v < PIX_FLOOR) ? PIX_FLOOR : v;
    endfunction

    function automatic logic [PIX_W-1:0] opening_code(input int idx, input logic first);
        if (!first) return CODE_SOL;
        case (idx)
            0, 2:    return CODE_MAX;
            1:       return CODE_IDLE;
            default: return CODE_SOL;
        endcase
    endfunction

    function automatic logic [PKT_W-1:0] build_packet(input sym_t s, input logic wide);
        logic [NAR_W-1:0] nar;
        if (s.is_code)
            nar = (s.val == CODE_MAX) ? '1 : s.val[NAR_W-1:0];
        else
            nar = (s.val[PIX_W-1:2] < NAR_FLOOR) ? NAR_FLOOR : s.val[PIX_W-1:2];
        if (wide)
            return {1'b0, s.val, 1'b1};
        return {1'b0, s.fv, s.lv, nar, 1'b1};
    endfunction

endpackage

// File: rtl/spk_lookahead.sv
module spk_lookahead
    import spk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pix_en,
    input  samp_t               din,
    output samp_t [LOOK-1:0]    taps
);

    genvar g;
    generate
        for (g = 0; g < LOOK; g++) begin : g_stage
            samp_t nxt;
            if (g == LOOK - 1) begin : g_last
                assign nxt = din;
            end else begin : g_mid
                assign nxt = taps[g+1];
            end
            always_ff @(posedge clk) begin
                if (rst)
                    taps[g] <= '0;
                else if (pix_en)
                    taps[g] <= nxt;
            end
        end
    endgenerate

endmodule

// File: rtl/spk_sequencer.sv
module spk_sequencer
    import spk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pix_en,
    input  samp_t               din,
    input  samp_t [LOOK-1:0]    taps,
    output sym_t                sym_q,
    output logic                sync_err
);

    samp_t [LOOK:0] win;
    logic           found;
    logic [CW-1:0]  start_k;
    logic [CW-1:0]  need;
    logic [CW-1:0]  pre_cnt;
    logic           first_now;
    logic           emit_pre;
    logic           prev_lv;
    logic           seen_line;
    logic           line_start;
    sym_t           nxt;

    always_comb begin
        win     = {din, taps};
        found   = 1'b0;
        start_k = '0;
        for (int k = 1; k <= LOOK; k++) begin
            if (!found && win[k].lv) begin
                found   = 1'b1;
                start_k = CW'(k);
            end
        end
        first_now   = !seen_line || !win[0].fv;
        need        = first_now ? CW'(LOOK) : CW'(1);
        emit_pre    = 1'b0;
        nxt.lv      = win[0].lv;
        nxt.fv      = win[0].fv;
        nxt.is_code = 1'b1;
        nxt.val     = CODE_IDLE;
        if (win[0].lv) begin
            nxt.is_code = 1'b0;
            nxt.val     = floor_pix(win[0].pix);
        end else if (prev_lv) begin
            nxt.val = win[0].fv ? CODE_EOL : CODE_EOF;
        end else if (found && start_k <= need) begin
            emit_pre = 1'b1;
            nxt.val  = opening_code(int'(need - start_k), first_now);
        end
    end

    assign line_start = win[0].lv && !prev_lv;

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q     <= '{lv: 1'b0, fv: 1'b0, is_code: 1'b1, val: CODE_IDLE};
            prev_lv   <= 1'b0;
            pre_cnt   <= '0;
            seen_line <= 1'b0;
            sync_err  <= 1'b0;
        end else if (pix_en) begin
            sym_q     <= nxt;
            prev_lv   <= win[0].lv;
            pre_cnt   <= emit_pre ? pre_cnt + CW'(1) : '0;
            if (!win[0].fv)
                seen_line <= 1'b0;
            else if (line_start)
                seen_line <= 1'b1;
            if (line_start && pre_cnt != need)
                sync_err <= 1'b1;
        end
    end

    assert_pixel_floor_R4: assert property (@(posedge clk) disable iff (rst)
        !sym_q.is_code |-> sym_q.val >= PIX_FLOOR);

    assert_line_close_R7: assert property (@(posedge clk) disable iff (rst)
        (pix_en && prev_lv && !win[0].lv) |=>
        (sym_q.is_code && (sym_q.val == CODE_EOL || sym_q.val == CODE_EOF)));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        sync_err |=> sync_err);

endmodule

// File: rtl/spk_serializer.sv
module spk_serializer
    import spk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_en,
    input  logic    wide_mode,
    input  sym_t    sym,
    output logic    ser_out,
    output logic    packet_start
);

    logic [BCW-1:0]   cnt;
    logic [PKT_W-2:0] shreg;
    logic [PKT_W-1:0] pkt;

    assign pkt = build_packet(sym, wide_mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            shreg        <= '0;
            ser_out      <= 1'b0;
            packet_start <= 1'b0;
        end else begin
            packet_start <= 1'b0;
            if (bit_en) begin
                if (cnt == '0) begin
                    ser_out      <= pkt[0];
                    shreg        <= pkt[PKT_W-1:1];
                    packet_start <= 1'b1;
                end else begin
                    ser_out <= shreg[0];
                    shreg   <= {1'b0, shreg[PKT_W-2:1]};
                end
                cnt <= (cnt == BCW'(PKT_W - 1)) ? '0 : cnt + BCW'(1);
            end
        end
    end

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        packet_start |-> ser_out);

    assert_stop_bit_R1: assert property (@(posedge clk) disable iff (rst)
        (bit_en && cnt == BCW'(PKT_W - 1)) |=> !ser_out);

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
        packet_start |=> !packet_start);

endmodule

// File: rtl/sync_packetizer.sv
module sync_packetizer
    import spk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             bit_en,
    input  logic             wide_mode,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             line_valid,
    input  logic             frame_valid,
    output logic             ser_out,
    output logic             packet_start,
    output logic             sync_err
);

    samp_t            din;
    samp_t [LOOK-1:0] taps;
    sym_t             sym;

    assign din = '{lv: line_valid, fv: frame_valid, pix: pix_in};

    spk_lookahead u_look (
        .clk    (clk),
        .rst    (rst),
        .pix_en (pix_en),
        .din    (din),
        .taps   (taps)
    );

    spk_sequencer u_seq (
        .clk      (clk),
        .rst      (rst),
        .pix_en   (pix_en),
        .din      (din),
        .taps     (taps),
        .sym_q    (sym),
        .sync_err (sync_err)
    );

    spk_serializer u_ser (
        .clk          (clk),
        .rst          (rst),
        .bit_en       (bit_en),
        .wide_mode    (wide_mode),
        .sym          (sym),
        .ser_out      (ser_out),
        .packet_start (packet_start)
    );

endmodule

// File: tb/tb_sync_packetizer.sv
`timescale 1ns/1ps
module tb_sync_packetizer;

    localparam int MAXN = 1500;
    localparam int LAT  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_en = 1'b0;
    logic       bit_en = 1'b1;
    logic       wide_mode = 1'b1;
    logic [9:0] pix_in = '0;
    logic       line_valid = 1'b0;
    logic       frame_valid = 1'b0;
    logic       ser_out;
    logic       packet_start;
    logic       sync_err;

    sync_packetizer dut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .bit_en(bit_en),
        .wide_mode(wide_mode), .pix_in(pix_in), .line_valid(line_valid),
        .frame_valid(frame_valid), .ser_out(ser_out),
        .packet_start(packet_start), .sync_err(sync_err)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    bit    in_lv [MAXN];
    bit    in_fv [MAXN];
    int    in_pix[MAXN];
    bit    ex_code[MAXN];
    int    ex_val [MAXN];
    string ex_tag [MAXN];
    int    n_in;
    int    pv;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            errors++;
            $display("FAIL watchdog: run did not complete (actual %0d cycles, expected <= 200000)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input bit lv, input bit fv, input int pix);
        if (n_in < MAXN) begin
            in_lv[n_in] = lv; in_fv[n_in] = fv; in_pix[n_in] = pix;
            n_in++;
        end
    endtask

    task automatic sweep_frame(input int lines, input int width);
        for (int b = 0; b < 6; b++) push(0, 0, 0);
        for (int b = 0; b < 5; b++) push(0, 1, 0);
        for (int l = 0; l < lines; l++) begin
            for (int x = 0; x < width; x++) begin
                push(1, 1, pv % 1024);
                pv++;
            end
            if (l != lines - 1)
                for (int b = 0; b < 3; b++) push(0, 1, 0);
        end
    endtask

    // Reference layout built from R4..R8 over the recorded input stream.
    task automatic build_expect();
        bit seen = 0;
        for (int i = 0; i < n_in; i++) begin
            ex_code[i] = 1; ex_val[i] = 0; ex_tag[i] = "R8";
            if (in_lv[i]) begin
                ex_code[i] = 0; ex_val[i] = in_pix[i];
                ex_tag[i] = (in_pix[i] < 16) ? "R4" : "";
            end
        end
        for (int i = 1; i < n_in; i++)
            if (!in_lv[i] && in_lv[i-1]) begin
                ex_val[i] = in_fv[i] ? 2 : 3; ex_tag[i] = "R7";
            end
        for (int i = 0; i < n_in; i++) begin
            if (!in_fv[i]) seen = 0;
            if (in_lv[i] && (i == 0 || !in_lv[i-1])) begin
                if (!seen) begin
                    ex_val[i-4] = 1023; ex_val[i-3] = 0; ex_val[i-2] = 1023; ex_val[i-1] = 1;
                    for (int q = 1; q <= 4; q++) ex_tag[i-q] = "R5";
                end else begin
                    ex_val[i-1] = 1; ex_tag[i-1] = "R6";
                end
                seen = 1;
            end
        end
    endtask

    function automatic logic [11:0] exp_packet(input int i, input bit wide);
        bit lv = 0, fv = 0, isc = 1;
        int v = 0, n;
        if (i >= 0 && i < n_in) begin
            lv = in_lv[i]; fv = in_fv[i]; isc = ex_code[i]; v = ex_val[i];
        end
        if (wide) begin
            if (!isc && v < 4) v = 4;
            return {1'b0, 10'(v), 1'b1};
        end
        if (isc) n = (v == 1023) ? 255 : (v & 255);
        else begin n = v >> 2; if (n < 4) n = 4; end
        return {1'b0, fv, lv, 8'(n), 1'b1};
    endfunction

    task automatic run_stream(input bit wide, input bit do_pkt, input bit err_exp);
        logic [11:0] cap;
        bit start_ok;
        bit hi_seen = 0;
        bit fell = 0;
        int idx;
        string tag;
        build_expect();
        wide_mode = wide;
        rst = 1; pix_en = 0; line_valid = 0; frame_valid = 0; pix_in = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(ser_out == 0, "R10", "ser_out in reset", ser_out, 0);
        check(packet_start == 0, "R10", "packet_start in reset", packet_start, 0);
        check(sync_err == 0, "R10", "sync_err in reset", sync_err, 0);
        rst = 0;
        cap = '0; start_ok = 1;
        for (int e = 0; e < (n_in + LAT + 2) * 12; e++) begin
            int j = e / 12;
            int b = e % 12;
            pix_en = (b == 11);
            if (j < n_in) begin
                line_valid = in_lv[j]; frame_valid = in_fv[j]; pix_in = 10'(in_pix[j]);
            end else begin
                line_valid = 0; frame_valid = 0; pix_in = '0;
            end
            @(negedge clk);
            cap[b] = ser_out;
            if (packet_start != (b == 0)) start_ok = 0;
            if (sync_err) hi_seen = 1;
            else if (hi_seen) fell = 1;
            if (b == 11 && do_pkt) begin
                idx = j - LAT;
                if (!start_ok) tag = "R1";
                else if (idx >= 0 && idx < n_in && ex_tag[idx] != "") tag = ex_tag[idx];
                else tag = wide ? "R2" : "R3";
                check(start_ok && cap == exp_packet(idx, wide), tag,
                      $sformatf("packet %0d", j), cap, exp_packet(idx, wide));
                start_ok = 1;
            end
        end
        pix_en = 0;
        // R9: flag level at end of run, and never fell once raised
        check(sync_err == err_exp, "R9", "sync_err at end of run", sync_err, err_exp);
        check(!fell, "R9", "sync_err fell after rising", fell, 0);
    endtask

    initial begin
        // 10-bit layout sweep over all pixel values plus the reserved run
        n_in = 0; pv = 0;
        for (int f = 0; f < 4; f++) sweep_frame(16, 16);
        for (int b = 0; b < 6; b++) push(0, 0, 0);
        for (int b = 0; b < 5; b++) push(0, 1, 0);
        push(1, 1, 1023); push(1, 1, 0); push(1, 1, 1023); push(1, 1, 5);
        for (int b = 0; b < 2; b++) push(0, 1, 0);
        push(1, 1, 1); push(1, 1, 1023); push(1, 1, 0); push(1, 1, 1023);
        for (int b = 0; b < 8; b++) push(0, 0, 0);
        run_stream(1, 1, 0);
        // 8-bit layout on the same stream
        run_stream(0, 1, 0);
        // short gap between two lines of one frame
        n_in = 0;
        for (int b = 0; b < 8; b++) push(0, 0, 0);
        for (int b = 0; b < 5; b++) push(0, 1, 0);
        for (int x = 0; x < 4; x++) push(1, 1, 100 + x);
        push(0, 1, 0);
        for (int x = 0; x < 4; x++) push(1, 1, 200 + x);
        for (int b = 0; b < 8; b++) push(0, 0, 0);
        for (int b = 0; b < 5; b++) push(0, 1, 0);
        for (int x = 0; x < 4; x++) push(1, 1, 300 + x);
        for (int b = 0; b < 8; b++) push(0, 0, 0);
        run_stream(1, 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule